// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Register Block

This block collects two hardware events, "message pending" (event 0) and "message taken" (event 1). It holds each one in a sticky raw status bit and lets software service them through a small word-addressed register port. A mask register selects which events may interrupt. A masked status view is the bitwise AND of the raw bits and the mask. Separate write-one registers let software clear or force any event. A level interrupt output, registered, is high while any unmasked event is pending.

An index register gives the single highest-priority unmasked pending event as a small code. A read of that register by the CPU also consumes the event it reports, so an interrupt handler can service events by reading it repeatedly. Each read carries an initiator tag. A read tagged as coming from the debug side returns the same code but changes nothing. Every request completes in one cycle, and read data is valid combinationally in the cycle of the request.

Top module: `irq_evt_regs`

## Requirements
- R1: Word address 0 (index) reads a code in bits [1:0]: 0 when no unmasked event is pending, 1 for event 0 (message pending), 2 for event 1 (message taken). A masked event never appears there.
- R2: When both events are pending and unmasked, the index reads 1, because the lower event number has the higher priority.
- R3: Word address 1 is the mask (bit i unmasks event i, read/write), address 2 reads the raw status and address 3 reads the masked status, equal to raw AND mask.
- R4: A CPU read (req_dbg_i=0) of address 0 returns the current code and, at the same clock edge, clears the raw bit of the reported event. A following read shows the next pending event, or 0.
- R5: A debug read (req_dbg_i=1) of address 0 returns the code and leaves all raw status bits unchanged.
- R6: Writing 1 to bit i of address 4 (clear) clears raw bit i even when event i is masked. A 0 bit leaves its raw bit unchanged.
- R7: Writing 1 to bit i of address 5 (set) sets raw bit i, and the masked bit follows when the event is unmasked. A 0 bit has no effect.
- R8: A pulse on evt_i[i] sets raw bit i. If it coincides with a clear write or a consuming read of that bit, the bit stays set.
- R9: irq_o is a register loaded each cycle with the OR of the masked status bits, so it follows them one clock later.
- R10: After reset the raw status, mask, masked status, index and irq_o are all zero.
- R11: Addresses 4 and 5 read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dbg_i | input | 1 | Initiator tag: 1 = debug side, 0 = CPU |
| req_addr_i | input | ADDR_W (3) | Word address |
| req_wdata_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Read data, valid in the request cycle |
| evt_i | input | NUM_EVT (2) | Hardware event pulses, bit 0 message pending, bit 1 message taken |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest situation to reach from the ports is a hardware event that lands in the very cycle a clear write hits the same bit. There the ordering of set and clear decides the result. The bench drives evt_i in the same cycle as the clear write, through its write task, and then reads the raw status back. The second hard case is telling a consuming read apart from a side-effect-free one. This takes two pending unmasked events: debug reads must keep returning the winner and leave the raw bits intact, while CPU reads must walk the code from 1 to 2 to 0.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

   // word offsets of the register map
   localparam int unsigned OFS_IDX  = 0;
   localparam int unsigned OFS_MASK = 1;
   localparam int unsigned OFS_RAW  = 2;
   localparam int unsigned OFS_MSTS = 3;
   localparam int unsigned OFS_CLR  = 4;
   localparam int unsigned OFS_SET  = 5;
   localparam int unsigned NUM_REGS = 6;

   // width of an index code able to hold 0 (none) .. n
   function automatic int unsigned code_width(int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_evt_status.sv
module irq_evt_status #(
   parameter int unsigned NUM_EVT = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [NUM_EVT-1:0] set_vec_i,
   input  logic [NUM_EVT-1:0] clr_vec_i,
   input  logic [NUM_EVT-1:0] take_vec_i,
   input  logic               mask_we_i,
   input  logic [NUM_EVT-1:0] mask_wdata_i,
   output logic [NUM_EVT-1:0] raw_o,
   output logic [NUM_EVT-1:0] mask_o,
   output logic [NUM_EVT-1:0] masked_o
);

   logic [NUM_EVT-1:0] raw_q;
   logic [NUM_EVT-1:0] mask_q;

   // one sticky bit per event: a rising cause beats any clearing cause
   for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
      logic rise;
      logic fall;
      assign rise = evt_i[g] | set_vec_i[g];
      assign fall = clr_vec_i[g] | take_vec_i[g];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            raw_q[g] <= 1'b0;
         end else if (rise) begin
            raw_q[g] <= 1'b1;
         end else if (fall) begin
            raw_q[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (mask_we_i) begin
         mask_q <= mask_wdata_i;
      end
   end

   assign raw_o    = raw_q;
   assign mask_o   = mask_q;
   assign masked_o = raw_q & mask_q;

endmodule

// File: rtl/irq_evt_prio.sv
module irq_evt_prio #(
   parameter int unsigned NUM_EVT = 2,
   parameter int unsigned CODE_W  = 2
) (
   input  logic [NUM_EVT-1:0] pend_i,
   output logic [CODE_W-1:0]  code_o,
   output logic [NUM_EVT-1:0] hot_o
);

   // scan from the weakest source up so the lowest index is left standing
   always_comb begin
      code_o = '0;
      hot_o  = '0;
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            code_o    = CODE_W'(i + 1);
            hot_o     = '0;
            hot_o[i]  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_evt_decode.sv
module irq_evt_decode
   import irq_evt_pkg::*;
#(
   parameter int unsigned NUM_EVT = 2,
   parameter int unsigned CODE_W  = 2,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic               req_dbg_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   input  logic [NUM_EVT-1:0] raw_i,
   input  logic [NUM_EVT-1:0] mask_i,
   input  logic [NUM_EVT-1:0] masked_i,
   input  logic [CODE_W-1:0]  code_i,
   output logic               mask_we_o,
   output logic [NUM_EVT-1:0] wbits_o,
   output logic [NUM_EVT-1:0] clr_vec_o,
   output logic [NUM_EVT-1:0] set_vec_o,
   output logic               take_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(OFS_IDX);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSTS = ADDR_W'(OFS_MSTS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);

   logic wr;
   logic rd;
   logic unused_wdata_hi;

   assign wr      = req_valid_i & req_write_i;
   assign rd      = req_valid_i & ~req_write_i;
   assign wbits_o = req_wdata_i[NUM_EVT-1:0];
   assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:NUM_EVT];

   assign mask_we_o = wr && (req_addr_i == A_MASK);
   assign clr_vec_o = (wr && (req_addr_i == A_CLR)) ? wbits_o : '0;
   assign set_vec_o = (wr && (req_addr_i == A_SET)) ? wbits_o : '0;
   // only the CPU consumes the reported event
   assign take_o    = rd && !req_dbg_i && (req_addr_i == A_IDX);

   always_comb begin
      rd_data_o = '0;
      if (rd) begin
         case (req_addr_i)
            A_IDX:   rd_data_o = DATA_W'(code_i);
            A_MASK:  rd_data_o = DATA_W'(mask_i);
            A_RAW:   rd_data_o = DATA_W'(raw_i);
            A_MSTS:  rd_data_o = DATA_W'(masked_i);
            default: rd_data_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/irq_evt_regs.sv
module irq_evt_regs #(
   parameter int unsigned NUM_EVT = 2,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic               req_dbg_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o
);

   localparam int unsigned CODE_W = irq_evt_pkg::code_width(NUM_EVT);

   if (NUM_EVT < 1) begin : g_chk_evt
      $error("NUM_EVT must be at least 1");
   end
   if (DATA_W <= NUM_EVT || DATA_W < CODE_W) begin : g_chk_data
      $error("DATA_W must exceed NUM_EVT and hold the index code");
   end
   if ((1 << ADDR_W) < irq_evt_pkg::NUM_REGS) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_EVT-1:0] raw_q;
   logic [NUM_EVT-1:0] mask_q;
   logic [NUM_EVT-1:0] masked;
   logic [NUM_EVT-1:0] win_hot;
   logic [NUM_EVT-1:0] wbits;
   logic [NUM_EVT-1:0] clr_vec;
   logic [NUM_EVT-1:0] set_vec;
   logic [NUM_EVT-1:0] take_vec;
   logic [CODE_W-1:0]  idx_code;
   logic               mask_we;
   logic               take;
   logic               irq_q;

   irq_evt_decode #(
      .NUM_EVT (NUM_EVT),
      .CODE_W  (CODE_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_decode (
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_dbg_i   (req_dbg_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .raw_i       (raw_q),
      .mask_i      (mask_q),
      .masked_i    (masked),
      .code_i      (idx_code),
      .mask_we_o   (mask_we),
      .wbits_o     (wbits),
      .clr_vec_o   (clr_vec),
      .set_vec_o   (set_vec),
      .take_o      (take),
      .rd_data_o   (rd_data_o)
   );

   irq_evt_prio #(
      .NUM_EVT (NUM_EVT),
      .CODE_W  (CODE_W)
   ) u_prio (
      .pend_i (masked),
      .code_o (idx_code),
      .hot_o  (win_hot)
   );

   assign take_vec = take ? win_hot : '0;

   irq_evt_status #(
      .NUM_EVT (NUM_EVT)
   ) u_status (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt_i),
      .set_vec_i    (set_vec),
      .clr_vec_i    (clr_vec),
      .take_vec_i   (take_vec),
      .mask_we_i    (mask_we),
      .mask_wdata_i (wbits),
      .raw_o        (raw_q),
      .mask_o       (mask_q),
      .masked_o     (masked)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= |masked;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_evt_regs_chk.sv
module irq_evt_regs_chk
   import irq_evt_pkg::*;
#(
   parameter int unsigned NUM_EVT = 2,
   parameter int unsigned CODE_W  = 2,
   parameter int unsigned ADDR_W  = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_valid_i,
   input logic               req_write_i,
   input logic               req_dbg_i,
   input logic [ADDR_W-1:0]  req_addr_i,
   input logic [NUM_EVT-1:0] evt_i,
   input logic [NUM_EVT-1:0] raw_q,
   input logic [NUM_EVT-1:0] mask_q,
   input logic [NUM_EVT-1:0] set_vec,
   input logic [CODE_W-1:0]  idx_code,
   input logic               irq_o
);

   logic idx_rd;
   assign idx_rd = req_valid_i && !req_write_i && (req_addr_i == ADDR_W'(OFS_IDX));

   // R1: a reported event is always unmasked
   p_idx_unmasked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx_code != '0) |-> mask_q[idx_code - 1'b1]);

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      localparam logic [NUM_EVT-1:0] LOWER = NUM_EVT'((1 << g) - 1);

      // R2: no stronger unmasked event pends while event g is reported
      p_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (idx_code == CODE_W'(g + 1)) |-> ((raw_q & mask_q & LOWER) == '0));

      // R4: a CPU index read consumes the reported event
      p_consume_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (idx_rd && !req_dbg_i && idx_code == CODE_W'(g + 1)
          && !evt_i[g] && !set_vec[g]) |=> !raw_q[g]);

      // R8: a hardware event always lands
      p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_i[g] |=> raw_q[g]);
   end

   // R5: a debug index read has no side effect
   p_dbg_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx_rd && req_dbg_i && evt_i == '0) |=> $stable(raw_q));

   // R9: interrupt is the masked OR delayed by one register
   p_irq_lag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_o == $past(|(raw_q & mask_q))));

endmodule

bind irq_evt_regs irq_evt_regs_chk #(
   .NUM_EVT (NUM_EVT),
   .CODE_W  (CODE_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_write_i (req_write_i),
   .req_dbg_i   (req_dbg_i),
   .req_addr_i  (req_addr_i),
   .evt_i       (evt_i),
   .raw_q       (raw_q),
   .mask_q      (mask_q),
   .set_vec     (set_vec),
   .idx_code    (idx_code),
   .irq_o       (irq_o)
);

// File: tb/irq_evt_regs_bench.sv
`timescale 1ns/1ps
module irq_evt_regs_bench;

   localparam int unsigned NUM_EVT = 2;
   localparam int unsigned ADDR_W  = 3;
   localparam int unsigned DATA_W  = 32;

   localparam logic [ADDR_W-1:0] A_IDX = 3'd0, A_MASK = 3'd1, A_RAW = 3'd2,
                                 A_MSTS = 3'd3, A_CLR = 3'd4, A_SET = 3'd5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic               req_write = 1'b0;
   logic               req_dbg = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [DATA_W-1:0]  req_wdata = '0;
   logic [DATA_W-1:0]  rd_data;
   logic [NUM_EVT-1:0] evt = '0;
   logic               irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_evt_regs #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irq_evt_regs (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_write_i (req_write),
      .req_dbg_i   (req_dbg),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .rd_data_o   (rd_data),
      .evt_i       (evt),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all ops start and end just after a falling edge
   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [NUM_EVT-1:0] ev);
      req_valid = 1'b1; req_write = 1'b1; req_dbg = 1'b0;
      req_addr = a; req_wdata = d; evt = ev;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; evt = '0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic dbg,
                         output logic [DATA_W-1:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_dbg = dbg; req_addr = a;
      #1 d = rd_data;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_dbg = 1'b0;
   endtask

   task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic dbg,
                            input logic [DATA_W-1:0] exp, input string req);
      logic [DATA_W-1:0] d;
      bus_rd(a, dbg, d);
      check(req, d, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R10 irq", {31'd0, irq}, 32'd0);
      expect_rd(A_RAW,  1'b1, 32'd0, "R10 raw");
      expect_rd(A_MASK, 1'b1, 32'd0, "R10 mask");
      expect_rd(A_MSTS, 1'b1, 32'd0, "R10 masked");
      expect_rd(A_IDX,  1'b1, 32'd0, "R10 index");
   endtask

   task automatic t_set_mask;
      bus_wr(A_SET, 32'h0, 2'b00);
      expect_rd(A_RAW, 1'b1, 32'd0, "R7 zero write no effect");
      bus_wr(A_SET, 32'h3, 2'b00);
      expect_rd(A_RAW,  1'b1, 32'd3, "R7 set raw");
      expect_rd(A_MSTS, 1'b1, 32'd0, "R3 masked all off");
      expect_rd(A_IDX,  1'b1, 32'd0, "R1 masked not indexed");
      check("R9 irq low while masked", {31'd0, irq}, 32'd0);
      bus_wr(A_MASK, 32'h2, 2'b00);
      expect_rd(A_MSTS, 1'b1, 32'd2, "R3 masked = raw & mask");
      expect_rd(A_IDX,  1'b1, 32'd2, "R1 code for message taken");
      bus_wr(A_MASK, 32'h3, 2'b00);
      expect_rd(A_MASK, 1'b1, 32'd3, "R3 mask readback");
      expect_rd(A_IDX,  1'b1, 32'd1, "R2 lower event wins");
      check("R9 irq high", {31'd0, irq}, 32'd1);
   endtask

   task automatic t_debug_read;
      expect_rd(A_IDX, 1'b1, 32'd1, "R5 debug read code");
      expect_rd(A_IDX, 1'b1, 32'd1, "R5 debug read repeat");
      expect_rd(A_RAW, 1'b1, 32'd3, "R5 raw untouched");
   endtask

   task automatic t_consume;
      expect_rd(A_IDX, 1'b0, 32'd1, "R4 cpu read first");
      expect_rd(A_RAW, 1'b1, 32'd2, "R4 event 0 consumed");
      expect_rd(A_IDX, 1'b0, 32'd2, "R4 cpu read next");
      // raw cleared at that edge, irq register still holds the old OR
      check("R9 irq lags one cycle", {31'd0, irq}, 32'd1);
      idle(1);
      check("R9 irq falls", {31'd0, irq}, 32'd0);
      expect_rd(A_RAW, 1'b1, 32'd0, "R4 all consumed");
      expect_rd(A_IDX, 1'b0, 32'd0, "R4 none left");
   endtask

   task automatic t_clear;
      bus_wr(A_MASK, 32'h0, 2'b00);
      bus_wr(A_SET,  32'h3, 2'b00);
      bus_wr(A_CLR,  32'h1, 2'b00);
      expect_rd(A_RAW, 1'b1, 32'd2, "R6 clear while masked");
      bus_wr(A_CLR,  32'h0, 2'b00);
      expect_rd(A_RAW, 1'b1, 32'd2, "R6 zero write no effect");
      expect_rd(A_CLR, 1'b0, 32'd0, "R11 clear reads zero");
      expect_rd(A_SET, 1'b0, 32'd0, "R11 set reads zero");
   endtask

   task automatic t_collide;
      bus_wr(A_CLR, 32'h2, 2'b10);
      expect_rd(A_RAW, 1'b1, 32'd2, "R8 event beats clear");
      bus_wr(A_CLR, 32'h2, 2'b00);
      expect_rd(A_RAW, 1'b1, 32'd0, "R6 clear after collision");
      evt = 2'b01;
      idle(1);
      evt = 2'b00;
      expect_rd(A_RAW, 1'b1, 32'd1, "R8 event sets raw");
      bus_wr(A_MASK, 32'h1, 2'b00);
      // consuming CPU read with a fresh event on the same bit
      evt = 2'b01;
      expect_rd(A_IDX, 1'b0, 32'd1, "R4 read during event");
      evt = 2'b00;
      expect_rd(A_RAW, 1'b1, 32'd1, "R8 event beats consume");
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_mask();
      t_debug_read();
      t_consume();
      t_clear();
      t_collide();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

endmodule